// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into a serial frame on a single data line. The frame format is chosen at run time. A character holds 5 to 9 data bits. Parity is off, even or odd, and the frame ends with one or two stop bits. A valid/ready handshake takes the character in. The format is frozen at the moment the character is accepted, so software may set up the next format while a frame is still going out.

Each bit of the frame moves to the next on a "step", and the source of the step depends on the mode. In asynchronous mode every baud tick is a step. In synchronous master mode the block makes its own shift clock by toggling it on each baud tick, and it steps on the toggle that is the change edge. In synchronous slave mode it follows an external shift clock. That clock passes through a synchronizer and an edge detector, and the block steps on its change edge. A polarity input decides whether the change edge is rising or falling. The line rests high between frames. A new character can be taken during the last stop bit, so frames can follow each other with no gap.

Top module: `frame_tx`

## Requirements
- R1: After reset, and with no frame loaded, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame opens with a single start bit of 0, followed by the data bits from least to most significant. The data bit count is 5 + `cfg_len` for codes 0 to 4, and codes 5 to 7 also select 9 bits. Bits of `in_data` above the selected count are never sent.
- R3: `cfg_par` selects parity: 2'b00 and 2'b01 add no parity bit, 2'b10 selects even and 2'b11 selects odd. For even parity, the sent data bits plus the parity bit hold an even count of ones; for odd parity the count is odd. The parity bit follows the last data bit.
- R4: After the data and any parity bit come one stop bit at 1, or two when `cfg_stop2` is 1. While no frame is loaded, `txd` is 1.
- R5: The frame format (`cfg_len`, `cfg_par`, `cfg_stop2`) and the data are captured in the cycle of acceptance. Later changes to them do not affect the frame being sent.
- R6: With `cfg_sync` = 0, each frame bit lasts from one `baud_tick` cycle to the next, and `txd` holds its value in every cycle without a tick.
- R7: With `cfg_sync` = 1 and `cfg_master` = 1, `sclk_oe` is 1. While `busy`, `sclk_out` toggles on every `baud_tick`. In a cycle that follows an idle cycle, `sclk_out` equals the inverse of `cfg_pol`. `txd` advances only on the toggle that forms a rising edge when `cfg_pol` = 0, or a falling edge when `cfg_pol` = 1. `sclk_out` follows the same toggle rule in every mode, and `sclk_oe` is 0 outside synchronous master mode.
- R8: With `cfg_sync` = 1 and `cfg_master` = 0, `sclk_oe` is 0. `txd` advances on the third system clock edge that samples a new `sclk_in` level, when that level change is a rising edge for `cfg_pol` = 0 or a falling edge for `cfg_pol` = 1.
- R9: `in_ready` is 1 when no frame is loaded, or when the last stop bit ends in the current cycle, and 0 otherwise. A word taken while the last stop bit ends begins its start bit in the next cycle, with no idle bit between.
- R10: `busy` is 1 from the cycle after acceptance until the last stop bit has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Bit-rate strobe (asynchronous bit time, or half period of the master shift clock) |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character taken in this cycle when `in_valid` is 1 |
| in_data | input | DATA_W | Character, bit 0 sent first |
| cfg_len | input | 3 | Data length code, 5 + code bits, capped at 9 |
| cfg_par | input | 2 | Parity select: 0x none, 10 even, 11 odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_sync | input | 1 | 1 selects synchronous mode |
| cfg_master | input | 1 | In synchronous mode, 1 drives the shift clock |
| cfg_pol | input | 1 | 0: data changes on rising shift-clock edge; 1: on falling edge |
| sclk_in | input | 1 | External shift clock (slave) |
| sclk_out | output | 1 | Generated shift clock (master) |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| txd | output | 1 | Serial data line |
| busy | output | 1 | A frame is loaded |

## Verification
The checker watches invariants that must hold on every cycle. The line and `in_ready` stay high while idle. An accepted character always starts its next cycle with `busy` set and a low start bit. In asynchronous mode `txd` never moves without a tick. The shift clock enable follows the mode, the master clock settles to its idle level after an idle cycle, and a transfer at the last stop bit leaves no idle gap. The bit order, the length cap, the parity value, the stop count, the format capture and the slave synchronizer latency all depend on the whole frame. Only the bench's cycle-by-cycle reference model can show them, and it compares the line, `busy`, `in_ready` and the shift clock on every clock across all three modes, both polarities and several formats.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
package frame_tx_pkg;

   localparam int unsigned LEN_CODE_W = 3;

   // format captured with each character
   typedef struct packed {
      logic [LEN_CODE_W-1:0] len_code;
      logic [1:0]            par_sel;   // [1]=enable, [0]=odd
      logic                  two_stop;
   } frame_fmt_t;

   typedef enum logic [1:0] {
      STEP_ASYNC  = 2'd0,
      STEP_MASTER = 2'd1,
      STEP_SLAVE  = 2'd2
   } step_src_e;

endpackage

// File: rtl/frame_tx_builder.sv
`timescale 1ns/1ps
module frame_tx_builder
   import frame_tx_pkg::*;
#(
   parameter int unsigned DATA_W   = 9,
   parameter int unsigned MIN_BITS = 5,
   parameter int unsigned FRAME_W  = DATA_W + 4,
   parameter int unsigned CNT_W    = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  frame_fmt_t         fmt,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);

   int   n_data;
   int   n_par;
   int   n_stop;
   logic pbit;

   always_comb begin
      n_data = int'(MIN_BITS) + int'(fmt.len_code);
      if (n_data > int'(DATA_W))
         n_data = int'(DATA_W);
      n_par  = fmt.par_sel[1] ? 1 : 0;
      n_stop = fmt.two_stop ? 2 : 1;

      // idle-high fill covers stop bits and unused positions
      frame    = '1;
      frame[0] = 1'b0;
      pbit     = fmt.par_sel[0];
      for (int i = 0; i < int'(DATA_W); i++) begin
         if (i < n_data) begin
            frame[i+1] = data[i];
            pbit       = pbit ^ data[i];
         end
      end
      for (int j = 1; j < int'(FRAME_W); j++) begin
         if (fmt.par_sel[1] && (j == n_data + 1))
            frame[j] = pbit;
      end
      nbits = CNT_W'(1 + n_data + n_par + n_stop);
   end

endmodule

// File: rtl/frame_tx_stepgen.sv
`timescale 1ns/1ps
module frame_tx_stepgen
   import frame_tx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          ENABLE_SLAVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic baud_tick,
   input  logic sclk_in,
   input  logic cfg_sync,
   input  logic cfg_master,
   input  logic cfg_pol,
   output logic step,
   output logic sclk_out,
   output logic sclk_oe
);

   step_src_e src;
   logic      ext_change;
   logic      mclk_q;

   always_comb begin
      if (!cfg_sync)      src = STEP_ASYNC;
      else if (cfg_master) src = STEP_MASTER;
      else                 src = STEP_SLAVE;
   end

   // master shift clock: rests at the sample level, toggles per tick
   always_ff @(posedge clk) begin
      if (!rst_n)
         mclk_q <= 1'b1;
      else if (!busy)
         mclk_q <= ~cfg_pol;
      else if (baud_tick)
         mclk_q <= ~mclk_q;
   end

   generate
      if (ENABLE_SLAVE) begin : g_slave
         logic [SYNC_STAGES-1:0] sync_q;
         logic                   prev_q;
         logic                   lvl;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '0;
               prev_q <= 1'b0;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_in};
               prev_q <= sync_q[SYNC_STAGES-1];
            end
         end

         assign lvl        = sync_q[SYNC_STAGES-1];
         assign ext_change = cfg_pol ? (prev_q & ~lvl) : (lvl & ~prev_q);
      end else begin : g_no_slave
         assign ext_change = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (src)
         STEP_ASYNC:  step = busy & baud_tick;
         STEP_MASTER: step = busy & baud_tick & (mclk_q == cfg_pol);
         STEP_SLAVE:  step = busy & ext_change;
         default:     step = 1'b0;
      endcase
   end

   assign sclk_out = mclk_q;
   assign sclk_oe  = (src == STEP_MASTER);

endmodule

// File: rtl/frame_tx_shifter.sv
`timescale 1ns/1ps
module frame_tx_shifter #(
   parameter int unsigned FRAME_W = 13,
   parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_frame,
   input  logic [CNT_W-1:0]   load_nbits,
   input  logic               step,
   output logic               line,
   output logic               busy,
   output logic               last
);

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= load_frame;
         left_q <= load_nbits;
      end else if (step) begin
         sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
         left_q <= left_q - 1'b1;
      end
   end

   assign busy = (left_q != '0);
   assign last = (left_q == CNT_W'(1));
   assign line = busy ? sh_q[0] : 1'b1;

endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
module frame_tx
   import frame_tx_pkg::*;
#(
   parameter int unsigned DATA_W       = 9,
   parameter int unsigned MIN_BITS     = 5,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          ENABLE_SLAVE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  baud_tick,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [DATA_W-1:0]     in_data,
   input  logic [LEN_CODE_W-1:0] cfg_len,
   input  logic [1:0]            cfg_par,
   input  logic                  cfg_stop2,
   input  logic                  cfg_sync,
   input  logic                  cfg_master,
   input  logic                  cfg_pol,
   input  logic                  sclk_in,
   output logic                  sclk_out,
   output logic                  sclk_oe,
   output logic                  txd,
   output logic                  busy
);

   localparam int unsigned FRAME_W = DATA_W + 4;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("frame_tx: SYNC_STAGES must be at least 2");
      end
      if (MIN_BITS < 1 || MIN_BITS > DATA_W) begin : g_bad_len
         $error("frame_tx: MIN_BITS must lie in 1..DATA_W");
      end
   endgenerate

   frame_fmt_t         fmt;
   logic [FRAME_W-1:0] new_frame;
   logic [CNT_W-1:0]   new_nbits;
   logic               step;
   logic               last;
   logic               take;

   assign fmt = '{len_code: cfg_len, par_sel: cfg_par, two_stop: cfg_stop2};

   frame_tx_builder #(
      .DATA_W   (DATA_W),
      .MIN_BITS (MIN_BITS),
      .FRAME_W  (FRAME_W),
      .CNT_W    (CNT_W)
   ) u_build (
      .data  (in_data),
      .fmt   (fmt),
      .frame (new_frame),
      .nbits (new_nbits)
   );

   frame_tx_stepgen #(
      .SYNC_STAGES  (SYNC_STAGES),
      .ENABLE_SLAVE (ENABLE_SLAVE)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .baud_tick  (baud_tick),
      .sclk_in    (sclk_in),
      .cfg_sync   (cfg_sync),
      .cfg_master (cfg_master),
      .cfg_pol    (cfg_pol),
      .step       (step),
      .sclk_out   (sclk_out),
      .sclk_oe    (sclk_oe)
   );

   assign in_ready = ~busy | (last & step);
   assign take     = in_valid & in_ready;

   frame_tx_shifter #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (take),
      .load_frame (new_frame),
      .load_nbits (new_nbits),
      .step       (step),
      .line       (txd),
      .busy       (busy),
      .last       (last)
   );

endmodule

// File: rtl/frame_tx_chk.sv
`timescale 1ns/1ps
module frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic in_valid,
   input logic in_ready,
   input logic cfg_sync,
   input logic cfg_master,
   input logic cfg_pol,
   input logic sclk_out,
   input logic sclk_oe,
   input logic txd,
   input logic busy
);

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd); // R4

   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> in_ready); // R9

   AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (busy && !txd)); // R2

   AST_NO_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_valid && in_ready) |=> busy); // R9

   AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cfg_sync && !baud_tick) |=> $stable(txd)); // R6

   AST_MASTER_DRIVES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sync && cfg_master) |-> sclk_oe); // R7

   AST_MASTER_CLK_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (sclk_out != $past(cfg_pol))); // R7

   AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sync && !cfg_master) |-> !sclk_oe); // R8

endmodule

bind frame_tx frame_tx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .baud_tick  (baud_tick),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .cfg_sync   (cfg_sync),
   .cfg_master (cfg_master),
   .cfg_pol    (cfg_pol),
   .sclk_out   (sclk_out),
   .sclk_oe    (sclk_oe),
   .txd        (txd),
   .busy       (busy)
);

// File: tb/sim_frame_tx.sv
`timescale 1ns/1ps
module sim_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [8:0] in_data = '0;
   logic [2:0] cfg_len = 3'd3;
   logic [1:0] cfg_par = 2'b00;
   logic       cfg_stop2 = 1'b0;
   logic       cfg_sync = 1'b0;
   logic       cfg_master = 1'b0;
   logic       cfg_pol = 1'b0;
   logic       sclk_in = 1'b0;
   logic       sclk_out;
   logic       sclk_oe;
   logic       txd;
   logic       busy;

   always #2.5 clk = ~clk;

   frame_tx u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .cfg_len    (cfg_len),
      .cfg_par    (cfg_par),
      .cfg_stop2  (cfg_stop2),
      .cfg_sync   (cfg_sync),
      .cfg_master (cfg_master),
      .cfg_pol    (cfg_pol),
      .sclk_in    (sclk_in),
      .sclk_out   (sclk_out),
      .sclk_oe    (sclk_oe),
      .txd        (txd),
      .busy       (busy)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R2";

   // reference model state
   bit    q[$];          // bits still to send, front is on the line
   int    pw[$];         // words waiting to be offered
   bit    msclk = 1'b1;  // model of the master shift clock
   bit    h1 = 0, h2 = 0, hp = 0;
   int    tick_per = 4;
   int    tcnt = 0;
   bit    tick_en = 1'b1;
   bit    slv_en = 1'b0;
   int    slv_half = 5;
   int    scnt = 0;

   task automatic chk(string req, logic act, logic exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic void build_frame(int d);
      int n;
      int ones;
      bit b;
      n = (cfg_len > 3'd4) ? 9 : 5 + int'(cfg_len);
      ones = 0;
      q.push_back(1'b0);
      for (int i = 0; i < n; i++) begin
         b = bit'((d >> i) & 1);
         q.push_back(b);
         ones += int'(b);
      end
      if (cfg_par[1])
         q.push_back(cfg_par[0] ? bit'((ones % 2) == 0) : bit'((ones % 2) == 1));
      q.push_back(1'b1);
      if (cfg_stop2)
         q.push_back(1'b1);
   endfunction

   // one clock: drive inputs at a falling edge, predict, compare after next falling edge
   task automatic cyc();
      bit busy0, stp, rdy, acc;
      baud_tick = tick_en && ((tcnt % tick_per) == tick_per - 1);
      tcnt++;
      if (slv_en) begin
         scnt++;
         if (scnt == slv_half) begin
            scnt    = 0;
            sclk_in = ~sclk_in;
         end
      end
      in_valid = (pw.size() > 0);
      in_data  = (pw.size() > 0) ? pw[0][8:0] : 9'd0;
      #1;
      busy0 = (q.size() > 0);
      if (!cfg_sync)
         stp = busy0 && baud_tick;
      else if (cfg_master)
         stp = busy0 && baud_tick && (msclk == cfg_pol);
      else
         stp = busy0 && (cfg_pol ? (hp && !h2) : (h2 && !hp));
      rdy = !busy0 || (q.size() == 1 && stp);
      chk("R9", in_ready, rdy, "in_ready");
      acc = in_valid && rdy;
      if (stp) void'(q.pop_front());
      if (acc) build_frame(pw.pop_front());
      if (!busy0)        msclk = !cfg_pol;
      else if (baud_tick) msclk = !msclk;
      hp = h2;
      h2 = h1;
      h1 = sclk_in;
      @(negedge clk);
      chk(cur_req, txd, (q.size() > 0) ? q[0] : 1'b1, "txd");
      chk("R10", busy, q.size() > 0, "busy");
      chk("R7", sclk_out, msclk, "sclk_out");
      chk((cfg_sync && !cfg_master) ? "R8" : "R7", sclk_oe, cfg_sync && cfg_master, "sclk_oe");
   endtask

   task automatic drain();
      while (pw.size() > 0 || q.size() > 0) cyc();
      repeat (4) cyc();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", txd, 1'b1, "reset txd");
      chk("R1", busy, 1'b0, "reset busy");
      chk("R1", in_ready, 1'b1, "reset in_ready");

      // R2 R6: asynchronous 8 data bits, no parity, one stop; bit 8 must not be sent
      cur_req = "R2"; tick_per = 4;
      cfg_len = 3'd3; cfg_par = 2'b00; cfg_stop2 = 1'b0;
      pw.push_back(9'h0A5); drain();
      cur_req = "R6"; tick_per = 7;
      pw.push_back(9'h13C); drain();

      // R3: five bits with even parity, then reserved no-parity code
      cur_req = "R3"; tick_per = 3;
      cfg_len = 3'd0; cfg_par = 2'b10;
      pw.push_back(9'h1F3); pw.push_back(9'h005); drain();
      cfg_par = 2'b01;
      pw.push_back(9'h016); drain();

      // R4 R9: nine bits, odd parity, two stops, queued back to back
      cur_req = "R4";
      cfg_len = 3'd4; cfg_par = 2'b11; cfg_stop2 = 1'b1;
      pw.push_back(9'h1A5); pw.push_back(9'h100); pw.push_back(9'h0FF); drain();

      // R2: length code 7 selects nine bits
      cur_req = "R2";
      cfg_len = 3'd7; cfg_par = 2'b00; cfg_stop2 = 1'b0;
      pw.push_back(9'h155); drain();

      // R5: format change while a frame is in flight
      cur_req = "R5";
      cfg_len = 3'd1; cfg_par = 2'b10; cfg_stop2 = 1'b1;
      pw.push_back(9'h0E9);
      repeat (12) cyc();
      cfg_len = 3'd4; cfg_par = 2'b00; cfg_stop2 = 1'b0;
      drain();

      // R7: synchronous master, both polarities
      cur_req = "R7"; tick_per = 3;
      cfg_sync = 1'b1; cfg_master = 1'b1; cfg_pol = 1'b0;
      cfg_len = 3'd3; cfg_par = 2'b10; cfg_stop2 = 1'b0;
      repeat (3) cyc();
      pw.push_back(9'h0C3); pw.push_back(9'h01E); drain();
      cfg_pol = 1'b1;
      repeat (3) cyc();
      pw.push_back(9'h07A); drain();

      // R8: synchronous slave, both polarities
      cur_req = "R8"; tick_en = 1'b0;
      cfg_master = 1'b0; cfg_pol = 1'b0; cfg_len = 3'd2; cfg_par = 2'b11;
      sclk_in = 1'b0; scnt = 0; slv_half = 5; slv_en = 1'b1;
      repeat (4) cyc();
      pw.push_back(9'h04D); pw.push_back(9'h072); drain();
      cfg_pol = 1'b1; slv_half = 4;
      repeat (4) cyc();
      pw.push_back(9'h033); drain();
      slv_en = 1'b0;

      // R1: back to idle
      cfg_sync = 1'b0; tick_en = 1'b1;
      repeat (4) cyc();
      chk("R1", txd, 1'b1, "idle txd");
      chk("R1", busy, 1'b0, "idle busy");

      summary();
      $finish;
   end

endmodule